// File: doc/BRIEF.md
# Converter Serial Readout State Machine

This block is the digital sequencer of a sampling converter with a 32-bit serial result port. Once reset ends it waits out a power-on interval and then runs a cycle that never stops: convert, sleep while holding the result, shift the result out to the host, and convert again. A programmable cycle counter stands in for the conversion engine. When that count expires, the block captures the 32-bit parallel word on `conv_data` as the result.

The host uses an active-low chip select and a serial clock that it drives itself. Both inputs are resynchronised into the system clock domain. Pulling chip select low while the block sleeps starts the frame, and the most significant bit appears on the data line at once. Each later bit is presented after a falling edge of the serial clock, so the host samples on the rising edge. A frame ends after 32 falling edges, or earlier when chip select returns high. Either way a new conversion begins immediately. While a conversion runs and chip select is low, the data line carries a high busy level.

Top module: `adc_readout_fsm`

## Requirements
- R1: After synchronous reset is released, `busy` stays 1 for POR_CYCLES power-on cycles plus CONV_CYCLES conversion cycles, POR_CYCLES + CONV_CYCLES clock edges in total, and then drops to 0 with no host action.
- R2: At the end of a conversion the block captures `conv_data`. A frame read later returns that captured word even if `conv_data` changed while the block was asleep with chip select high.
- R3: `sdo_oe` is 1 exactly when the synchronised chip select (`cs_n` delayed by two clock edges) is low, and 0 otherwise, including during reset.
- R4: The result is sent most significant bit first. When chip select is low in sleep, bit 31 is on `sdo` by the time `sdo_oe` rises. A chip select already low when a conversion ends gets its frame without being raised again.
- R5: `sdo` changes only after a synchronised falling edge of `sclk` and is stable across the rising edge where the host samples it.
- R6: After the 32nd synchronised falling edge of `sclk` the frame ends and `busy` returns to 1 as a new conversion starts.
- R7: Raising chip select before 32 bits have been read ends the frame and starts a new conversion.
- R8: While `busy` is 1 and chip select is low, `sdo` is 1.
- R9: A chip-select low pulse that starts and ends inside a conversion does not change that conversion's length. The next frame then delivers all 32 bits of that conversion's result.
- R10: Asserting `rst` in the middle of a frame returns the block to the power-on interval (`busy` = 1, `sdo_oe` = 0), and the full R1 sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| conv_data | input | 32 | Parallel result from the conversion stand-in |
| sdo | output | 1 | Serial data out, MSB first, or busy level |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means high-impedance |
| busy | output | 1 | 1 during power-on interval and conversion |

## Verification
Two situations are hard to reach from the ports, and both depend on the two-edge synchroniser delay. One is a chip-select pulse that lies entirely inside a conversion. The other is a frame that ends while chip select stays low, so the next frame starts from an asleep state with chip select already low. The stimulus uses `busy` to find the conversion window: it opens the pulse a few cycles after an aborted frame, well before the counter expires, and it keeps chip select low across a frame end into the next sleep. A behavioural model that applies the same synchroniser delays is compared with the outputs on every clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_POR,
        ST_CONV,
        ST_SLEEP,
        ST_OUT
    } rd_state_t;

    typedef struct packed {
        logic level;
        logic fall;
    } pin_view_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync
    import adc_rd_pkg::*;
#(
    parameter bit RST_VAL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_view_t view
);
    logic stage1, stage2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
            prev   <= RST_VAL;
        end else begin
            stage1 <= pin;
            stage2 <= stage1;
            prev   <= stage2;
        end
    end

    always_comb begin
        view.level = stage2;
        view.fall  = prev & ~stage2;
    end
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W     = 32,
    parameter int BIT_W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         last
);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(W - 1);

    logic [W-1:0]     word;
    logic [BIT_W-1:0] sent;

    assign msb  = word[W-1];
    assign last = (sent == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            sent <= '0;
        end else if (load) begin
            word <= din;
            sent <= '0;
        end else if (shift) begin
            word <= {word[W-2:0], 1'b0};
            sent <= sent + 1'b1;
        end
    end
endmodule

// File: rtl/adc_readout_fsm.sv
module adc_readout_fsm
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CONV_CYCLES = 64,
    parameter int POR_CYCLES  = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy
);
    localparam int CNT_W = cnt_width(max_int(POR_CYCLES, CONV_CYCLES) + 1);
    localparam int BIT_W = cnt_width(DATA_W);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

    rd_state_t        state, nxt;
    pin_view_t        cs_v, sk_v;
    logic             tmr_done, sh_last, sh_msb;
    logic             load, shift;
    logic [CNT_W-1:0] limit;

    adc_rd_sync #(.RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .pin(cs_n), .view(cs_v)
    );

    adc_rd_sync #(.RST_VAL(1'b0)) u_sk_sync (
        .clk(clk), .rst(rst), .pin(sclk), .view(sk_v)
    );

    assign limit = (state == ST_POR) ? POR_LAST : CONV_LAST;

    adc_rd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .run(busy), .last(limit), .done(tmr_done)
    );

    assign load  = (state == ST_CONV) && tmr_done;
    assign shift = (state == ST_OUT) && !cs_v.level && sk_v.fall;

    adc_rd_shifter #(.W(DATA_W), .BIT_W(BIT_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .din(conv_data), .msb(sh_msb), .last(sh_last)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_POR:   if (tmr_done) nxt = ST_CONV;
            ST_CONV:  if (tmr_done) nxt = ST_SLEEP;
            ST_SLEEP: if (!cs_v.level) nxt = ST_OUT;
            ST_OUT: begin
                if (cs_v.level)             nxt = ST_CONV;
                else if (shift && sh_last)  nxt = ST_CONV;
            end
            default:  nxt = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_POR;
        else     state <= nxt;
    end

    assign busy   = (state == ST_POR) || (state == ST_CONV);
    assign sdo_oe = !cs_v.level;
    assign sdo    = busy ? 1'b1 : sh_msb;

    // R1: the power-on interval can only lead into a conversion
    assert_por_to_conv_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POR) |=> (state == ST_POR || state == ST_CONV));

    // R2: the held result does not move while asleep with chip select high
    assert_sleep_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && cs_v.level) |=> (state == ST_SLEEP && $stable(sdo)));

    // R5: no serial clock fall, no change of the data bit
    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OUT && !cs_v.level && !sk_v.fall) |=> (state == ST_OUT && $stable(sdo)));

    // R6: the last falling edge of a frame starts a conversion
    assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OUT && !cs_v.level && sk_v.fall && sh_last) |=> busy);

    // R7: early chip select release starts a conversion
    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OUT && cs_v.level) |=> busy);

    // R8: busy level on the data line while selected
    assert_busy_level_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && sdo_oe) |-> sdo);
endmodule

// File: tb/adc_readout_fsm_bench.sv
`timescale 1ns/1ps
module adc_readout_fsm_bench;
    localparam int W    = 32;
    localparam int CONV = 40;
    localparam int POR  = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         sdo, sdo_oe, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_readout_fsm #(.DATA_W(W), .CONV_CYCLES(CONV), .POR_CYCLES(POR)) u_adc_readout_fsm (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .conv_data(conv_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 power-on, 1 convert, 2 sleep, 3 output
    int       m_ph = 0;
    int       m_cnt = 0;
    int       m_bits = 0;
    logic [W-1:0] m_word = '0;
    bit c1 = 1, c2 = 1, c3 = 1;
    bit k1 = 0, k2 = 0, k3 = 0;

    always @(posedge clk) begin
        bit fall, low;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_bits = 0; m_word = '0;
            c1 = 1; c2 = 1; c3 = 1; k1 = 0; k2 = 0; k3 = 0;
        end else begin
            fall = k3 && !k2;
            low  = !c2;
            case (m_ph)
                0: if (m_cnt == POR - 1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
                1: if (m_cnt == CONV - 1) begin m_ph = 2; m_cnt = 0; m_word = conv_data; end else m_cnt++;
                2: if (low) begin m_ph = 3; m_bits = 0; end
                default: begin
                    if (!low) m_ph = 1;
                    else if (fall) begin
                        m_word = m_word << 1;
                        if (m_bits == W - 1) m_ph = 1; else m_bits++;
                    end
                end
            endcase
            c3 = c2; c2 = c1; c1 = cs_n;
            k3 = k2; k2 = k1; k1 = sclk;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check(busy === (m_ph < 2), "R1 model busy", 32'(busy), 32'(m_ph < 2));
            check(sdo_oe === !c2, "R3 model sdo_oe", 32'(sdo_oe), 32'(!c2));
            if (!c2)
                check(sdo === ((m_ph < 2) ? 1'b1 : m_word[W-1]), "R4 model sdo",
                      32'(sdo), 32'((m_ph < 2) ? 1'b1 : m_word[W-1]));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_bits(input int n, input bit lower_cs, output logic [W-1:0] got);
        got = '0;
        if (lower_cs) begin
            cs_n = 1'b0;
            wait_n(3);
        end
        for (int i = 0; i < n; i++) begin
            logic b;
            sclk = 1'b1;
            b = sdo;
            got[W-1-i] = b;
            wait_n(3);
            check(sdo === b, "R5 bit stable through high phase", 32'(sdo), 32'(b));
            sclk = 1'b0;
            wait_n(3);
        end
    endtask

    task automatic measure_start(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 1000);
        check(n == POR + CONV, tag, 32'(n), 32'(POR + CONV));
    endtask

    initial begin
        logic [W-1:0] got;
        @(negedge clk);
        wait_n(2);
        check(busy === 1'b1, "R10 busy in reset", 32'(busy), 32'd1);
        check(sdo_oe === 1'b0, "R3 sdo_oe in reset", 32'(sdo_oe), 32'd0);
        conv_data = 32'hA5C3_0F96;
        rst = 1'b0;
        measure_start("R1 start-up length");

        // R2: change input during sleep, result held
        conv_data = 32'h1234_5678;
        wait_n(50);
        check(busy === 1'b0, "R2 still asleep", 32'(busy), 32'd0);
        cs_n = 1'b0;
        wait_n(2);
        check(sdo_oe === 1'b1, "R3 enable after select", 32'(sdo_oe), 32'd1);
        check(sdo === 1'b1, "R4 MSB at select", 32'(sdo), 32'd1);
        wait_n(1);
        for (int i = 0; i < W; i++) begin
            logic b;
            sclk = 1'b1; b = sdo; got[W-1-i] = b;
            wait_n(3);
            check(sdo === b, "R5 bit stable", 32'(sdo), 32'(b));
            sclk = 1'b0;
            wait_n(3);
        end
        check(got === 32'hA5C3_0F96, "R2 held frame", got, 32'hA5C3_0F96);
        check(busy === 1'b1, "R6 conversion after 32 bits", 32'(busy), 32'd1);
        wait_n(2);
        check(sdo === 1'b1, "R8 busy level on sdo", 32'(sdo), 32'd1);
        cs_n = 1'b1;

        // R7: abort after 5 bits
        wait_idle();
        read_bits(5, 1'b1, got);
        check(got[W-1:W-5] === 5'b00010, "R7 partial bits", 32'(got[W-1:W-5]), 32'b00010);
        cs_n = 1'b1;
        wait_n(3);
        check(busy === 1'b1, "R7 early release restarts", 32'(busy), 32'd1);

        // R9: select pulse inside a conversion
        cs_n = 1'b0;
        wait_n(4);
        check(sdo_oe === 1'b1, "R3 enable during pulse", 32'(sdo_oe), 32'd1);
        check(sdo === 1'b1, "R8 busy level during pulse", 32'(sdo), 32'd1);
        cs_n = 1'b1;
        conv_data = 32'h8000_0001;
        wait_n(4);
        check(busy === 1'b1, "R9 pulse left conversion running", 32'(busy), 32'd1);
        wait_idle();
        read_bits(W, 1'b1, got);
        check(got === 32'h8000_0001, "R9 full frame after pulse", got, 32'h8000_0001);

        // R4: select kept low across the frame end
        conv_data = 32'h7E81_3CC3;
        wait_idle();
        read_bits(W, 1'b0, got);
        check(got === 32'h7E81_3CC3, "R4 back-to-back frame", got, 32'h7E81_3CC3);
        cs_n = 1'b1;

        // R10: reset in the middle of a frame
        wait_idle();
        read_bits(3, 1'b1, got);
        rst = 1'b1;
        cs_n = 1'b1;
        wait_n(1);
        check(busy === 1'b1, "R10 busy after mid-frame reset", 32'(busy), 32'd1);
        check(sdo_oe === 1'b0, "R10 released after reset", 32'(sdo_oe), 32'd0);
        wait_n(2);
        rst = 1'b0;
        measure_start("R10 start-up repeats");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule